// File: doc/BRIEF.md
# Multi-Mode DMA Channel

This block is one bus-mastering copy engine. Software programs a 24-bit read pointer, a 24-bit write pointer, a 16-bit transfer count and a mode word through a small write-only register port. When the channel is armed and a peripheral raises its transfer request, the channel asks for the system bus. Once the bus is granted, it moves bytes one at a time. Each byte is read at the read pointer and then written at the write pointer. Both pointers then step up by one byte and the count steps down by one.

The three modes differ in how long the channel keeps the bus. In single mode the channel gives the bus back after every byte. In burst mode it keeps moving bytes for as long as the peripheral keeps its request high. In continuous mode it holds the bus until the whole count has been moved. When the count reaches zero, the channel raises a one-cycle completion interrupt, presents its own fixed interrupt vector with it, and disarms itself. Software can abort a run by clearing the enable bit. The byte in flight still completes, and the run can later be resumed from where it stopped.

Top module: `dma_channel`

## Requirements
- R1: After a synchronous reset, bus_req, bus_rd, bus_wr and eop_irq are all low and the channel is disarmed.
- R2: Register port: reg_sel 0 loads the read pointer, 1 loads the write pointer, 2 loads the count from reg_wdata[15:0], and 3 loads the mode word. In the mode word, bit 0 is enable and bits [2:1] select the mode: 0 single, 1 burst, 2 continuous, 3 behaves as single.
- R3: Each transfer is a read cycle (bus_rd high, bus_addr = read pointer, bus_rdata sampled) followed directly by a write cycle (bus_wr high, bus_addr = write pointer, bus_wdata = the byte read). Both pointers then increment by one, with the carry propagating through all 24 bits and wrapping at the top.
- R4: A run starts only when the channel is armed, the count is nonzero and xfer_req is high. The channel then holds bus_req high and never asserts bus_rd or bus_wr in a cycle without bus_gnt.
- R5: Single mode performs exactly one transfer per start and drops bus_req in the cycle after its write cycle.
- R6: Burst mode starts a new transfer directly after a write cycle if xfer_req is high in that write cycle. If xfer_req is low, it drops bus_req in the next cycle.
- R7: Continuous mode ignores xfer_req after the start and keeps bus_req high until the count reaches zero.
- R8: The count decreases by one per transfer. The transfer that brings it to zero is followed, in the next cycle, by a one-cycle eop_irq pulse with eop_vector equal to the VECTOR parameter; eop_vector is 0 otherwise. The channel then disarms, so reloading the count alone starts nothing.
- R9: Clearing the enable bit during a run lets the transfer in progress complete, then drops bus_req without an interrupt. The remaining count and pointers are kept, so re-arming resumes at the next byte.
- R10: An armed channel with a count of zero never requests the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 read ptr, 1 write ptr, 2 count, 3 mode) |
| reg_wdata | input | ADDR_W | Register write data |
| xfer_req | input | 1 | Transfer request from the peripheral |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_addr | output | ADDR_W | Byte address of the current bus cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled in the read cycle |
| eop_irq | output | 1 | One-cycle completion interrupt |
| eop_vector | output | VEC_W | Channel interrupt vector, valid with eop_irq |

## Verification
The bench builds the channel with its default sizes: 24-bit pointers, a 16-bit count, a byte data path and an 8-bit vector. With these sizes, placing the pointers just below 0x010000 and 0xFFFFFF brings both the 16-bit carry and the full 24-bit wrap within reach of a ten-byte run. Counts stay small, because the decrement and zero detection behave the same at any width. The grant input is driven by a one-cycle-delay arbiter model that can be held off, so the time spent waiting for the bus can be observed.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BURST  = 2'd1,
    XM_CONT   = 2'd2
  } xmode_e;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_ASK  = 2'd1,
    CH_READ = 2'd2,
    CH_WRITE = 2'd3
  } chst_e;

  localparam logic [1:0] SEL_RPTR = 2'd0;
  localparam logic [1:0] SEL_WPTR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              step,
  input  logic              finish,
  output logic [ADDR_W-1:0] rptr,
  output logic [ADDR_W-1:0] wptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              armed,
  output logic [1:0]        mode
);
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  // a transfer step owns the pointers and count; a load in the same cycle is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      rptr  <= '0;
      wptr  <= '0;
      cnt   <= '0;
      armed <= 1'b0;
      mode  <= 2'd0;
    end else begin
      if (step) begin
        rptr <= rptr + PTR_ONE;
        wptr <= wptr + PTR_ONE;
        cnt  <= cnt - CNT_ONE;
      end else if (wr_en) begin
        case (wr_sel)
          SEL_RPTR: rptr <= wr_data;
          SEL_WPTR: wptr <= wr_data;
          SEL_CNT:  cnt  <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
      if (wr_en && wr_sel == SEL_MODE) begin
        armed <= wr_data[0];
        mode  <= wr_data[2:1];
      end else if (finish) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       armed,
  input  logic [1:0] mode,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       xfer_req,
  input  logic       gnt,
  output chst_e      st,
  output logic       capture,
  output logic       step,
  output logic       finish
);
  chst_e st_n;

  assign capture = (st == CH_READ) && gnt;
  assign step    = (st == CH_WRITE) && gnt;
  assign finish  = step && cnt_last;

  always_comb begin
    st_n = st;
    case (st)
      CH_IDLE:  if (armed && !cnt_zero && xfer_req) st_n = CH_ASK;
      CH_ASK: begin
        if (!armed)   st_n = CH_IDLE;
        else if (gnt) st_n = CH_READ;
      end
      CH_READ:  if (gnt) st_n = CH_WRITE;
      CH_WRITE: begin
        if (gnt) begin
          if (cnt_last || !armed) st_n = CH_IDLE;
          else begin
            case (mode)
              XM_BURST: st_n = xfer_req ? CH_READ : CH_IDLE;
              XM_CONT:  st_n = CH_READ;
              default:  st_n = CH_IDLE;
            endcase
          end
        end
      end
      default: st_n = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= CH_IDLE;
    else     st <= st_n;
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int          ADDR_W = 24,
  parameter int          CNT_W  = 16,
  parameter int          DATA_W = 8,
  parameter int          VEC_W  = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              xfer_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              eop_irq,
  output logic [VEC_W-1:0]  eop_vector
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] rptr, wptr;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic [1:0]        mode_q;
  chst_e             st;
  logic              capture, step, finish;
  logic [DATA_W-1:0] hold_q;
  logic              irq_q;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .step(step), .finish(finish),
    .rptr(rptr), .wptr(wptr), .cnt(cnt), .armed(armed), .mode(mode_q)
  );

  dma_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .armed(armed), .mode(mode_q),
    .cnt_zero(cnt == '0), .cnt_last(cnt == CNT_ONE),
    .xfer_req(xfer_req), .gnt(bus_gnt),
    .st(st), .capture(capture), .step(step), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (capture) hold_q <= bus_rdata;
      irq_q <= finish;
    end
  end

  assign bus_req    = (st != CH_IDLE);
  assign bus_rd     = capture;
  assign bus_wr     = step;
  assign bus_addr   = (st == CH_WRITE) ? wptr : rptr;
  assign bus_wdata  = hold_q;
  assign eop_irq    = irq_q;
  assign eop_vector = irq_q ? VECTOR : '0;
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk
  import dma_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       eop_irq,
  input logic       xfer_req,
  input logic [1:0] mode_q
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!bus_req && !bus_rd && !bus_wr && !eop_irq));

  p_strobe_granted_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> (bus_gnt && bus_req));

  p_write_after_read_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr) |-> $past(bus_rd));

  p_single_release_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && mode_q == 2'(XM_SINGLE)) |=> !bus_req);

  p_burst_release_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && mode_q == 2'(XM_BURST) && !xfer_req) |=> !bus_req);

  p_irq_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    eop_irq |-> $past(bus_wr));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    eop_irq |=> !eop_irq);
endmodule

bind dma_channel dma_channel_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .eop_irq(eop_irq),
  .xfer_req(xfer_req), .mode_q(mode_q)
);

// File: tb/dma_channel_test.sv
module dma_channel_test;
  localparam int AW = 24;
  localparam int DW = 8;
  localparam logic [7:0] VEC = 8'h24;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic xfer_req = 1'b0, bus_gnt = 1'b0, allow = 1'b1;
  logic bus_req, bus_rd, bus_wr, eop_irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [7:0] eop_vector;

  int checks = 0, fails = 0, cyc = 0;
  int n_rd = 0, n_wr = 0, n_fall = 0, n_rise = 0, n_irq = 0, bad_vec = 0;
  logic req_prev = 1'b0;
  logic [AW-1:0] rd_a [0:63];
  logic [AW-1:0] wr_a [0:63];
  logic [DW-1:0] wr_d [0:63];

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  assign bus_rdata = pat(bus_addr);

  always @(posedge clk) bus_gnt <= rst ? 1'b0 : (bus_req & allow);

  dma_channel uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .xfer_req(xfer_req), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eop_irq(eop_irq), .eop_vector(eop_vector)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rd && n_rd < 64) begin rd_a[n_rd] = bus_addr; n_rd++; end
      if (bus_wr && n_wr < 64) begin wr_a[n_wr] = bus_addr; wr_d[n_wr] = bus_wdata; n_wr++; end
      if (req_prev && !bus_req) n_fall++;
      if (!req_prev && bus_req) n_rise++;
      if (eop_irq) begin n_irq++; if (eop_vector != VEC) bad_vec++; end
      else if (eop_vector != 8'h00) bad_vec++;
      req_prev = bus_req;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // caller is at a negedge; returns at the next negedge
  task automatic wreg(input logic [1:0] sel, input logic [AW-1:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_logs();
    n_rd = 0; n_wr = 0; n_fall = 0; n_rise = 0; n_irq = 0; bad_vec = 0;
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic [15:0] c, input logic [1:0] m);
    wreg(2'd0, s); wreg(2'd1, d); wreg(2'd2, {8'h00, c});
    wreg(2'd3, {21'd0, m, 1'b1});
  endtask

  task automatic pulse_req();
    xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic wait_writes(input int k);
    int seen = 0;
    while (seen < k) begin
      @(negedge clk);
      if (bus_wr) seen++;
    end
  endtask

  // log entries [first, first+num) must be transfers from s+i to d+i
  task automatic check_data(input string tag, input int first, input int num,
                            input logic [AW-1:0] s, input logic [AW-1:0] d);
    int bad = 0;
    for (int i = 0; i < num; i++) begin
      logic [AW-1:0] ea, ed;
      ea = s + AW'(i); ed = d + AW'(i);
      if (rd_a[first+i] != ea || wr_a[first+i] != ed || wr_d[first+i] != pat(ea)) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    chk(!bus_req && !bus_rd && !bus_wr, "R1 bus outputs idle after reset",
        {bus_req, bus_rd, bus_wr}, 0);
    chk(!eop_irq && eop_vector == 0, "R1 interrupt low after reset", eop_irq, 0);
    xfer_req = 1'b1; tick(8); xfer_req = 1'b0;
    chk(n_rise == 0, "R1 disarmed after reset ignores request", n_rise, 0);
  endtask

  task automatic t_disarmed_and_grant();
    clear_logs();
    wreg(2'd2, 24'd1);
    wreg(2'd3, {21'd0, 2'd0, 1'b0});
    xfer_req = 1'b1; tick(10); xfer_req = 1'b0;
    chk(n_rise == 0, "R4 disarmed channel does not request", n_rise, 0);
    allow = 1'b0;
    setup(24'h000040, 24'h000080, 16'd1, 2'd0);
    pulse_req(); tick(15);
    chk(bus_req == 1'b1, "R4 request held while grant absent", bus_req, 1);
    chk(n_rd == 0 && n_wr == 0, "R4 no strobes without grant", n_rd + n_wr, 0);
    allow = 1'b1; tick(20);
    chk(n_wr == 1, "R4 transfer after grant", n_wr, 1);
    check_data("R3 data of granted transfer", 0, 1, 24'h000040, 24'h000080);
  endtask

  task automatic t_single();
    clear_logs();
    setup(24'h000010, 24'h000100, 16'd3, 2'd0);
    pulse_req(); tick(20);
    chk(n_wr == 1, "R5 single: one transfer per request", n_wr, 1);
    chk(n_fall == 1 && !bus_req, "R5 single: bus released", n_fall, 1);
    chk(n_irq == 0, "R8 no interrupt before count reaches zero", n_irq, 0);
    xfer_req = 1'b1; tick(40);
    chk(n_wr == 3 && n_fall == 3, "R5 single: bus released after each transfer",
        n_fall, 3);
    chk(n_irq == 1 && bad_vec == 0, "R8 completion interrupt with vector", n_irq, 1);
    check_data("R3 single-mode addresses and data", 0, 3, 24'h000010, 24'h000100);
    wreg(2'd2, 24'd2); tick(20);
    chk(n_wr == 3, "R8 channel disarmed after completion", n_wr, 3);
    xfer_req = 1'b0; tick(2);
  endtask

  task automatic t_burst();
    clear_logs();
    setup(24'h00FFFE, 24'hFFFFFE, 16'd10, 2'd1);
    xfer_req = 1'b1;
    wait_writes(4);
    xfer_req = 1'b0;
    tick(10);
    chk(n_wr == 4, "R6 burst stops when request drops", n_wr, 4);
    chk(n_fall == 1 && n_rise == 1, "R6 burst held bus in one ownership", n_fall, 1);
    check_data("R3 carry across 16-bit and 24-bit wrap", 0, 4, 24'h00FFFE, 24'hFFFFFE);
    xfer_req = 1'b1; tick(40); xfer_req = 1'b0;
    chk(n_wr == 10 && n_fall == 2, "R6 burst resumes to completion", n_wr, 10);
    chk(n_irq == 1 && bad_vec == 0, "R8 burst completion interrupt", n_irq, 1);
    check_data("R3 burst full sequence", 0, 10, 24'h00FFFE, 24'hFFFFFE);
    tick(2);
  endtask

  task automatic t_cont();
    clear_logs();
    setup(24'h123400, 24'h000200, 16'd5, 2'd2);
    pulse_req(); tick(40);
    chk(n_wr == 5, "R7 continuous moves whole count", n_wr, 5);
    chk(n_fall == 1 && n_rise == 1, "R7 continuous single bus ownership", n_fall, 1);
    chk(n_irq == 1 && bad_vec == 0, "R8 continuous completion interrupt", n_irq, 1);
    check_data("R3 continuous data", 0, 5, 24'h123400, 24'h000200);
  endtask

  task automatic t_abort();
    clear_logs();
    setup(24'h000300, 24'h000500, 16'd8, 2'd2);
    pulse_req();
    wait_writes(2);
    @(negedge clk);
    wreg(2'd3, {21'd0, 2'd2, 1'b0});
    tick(15);
    chk(n_wr == 3, "R9 abort completes transfer in progress", n_wr, 3);
    chk(n_irq == 0 && !bus_req, "R9 abort releases bus without interrupt", n_irq, 0);
    wreg(2'd3, {21'd0, 2'd2, 1'b1});
    pulse_req(); tick(30);
    chk(n_wr == 8 && n_irq == 1, "R9 resume finishes remaining count", n_wr, 8);
    check_data("R9 resumed addresses continue", 0, 8, 24'h000300, 24'h000500);
  endtask

  task automatic t_zero();
    clear_logs();
    setup(24'h000000, 24'h000000, 16'd0, 2'd2);
    xfer_req = 1'b1; tick(20); xfer_req = 1'b0;
    chk(n_rise == 0, "R10 zero count never requests", n_rise, 0);
    chk(n_irq == 0, "R10 zero count no interrupt", n_irq, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disarmed_and_grant();
    t_single();
    t_burst();
    t_cont();
    t_abort();
    t_zero();
    // R2 is exercised by every setup() through the register port
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule